// File: doc/BRIEF.md
# PS/2 Frame Receiver

This block takes the two open-collector lines of a PS/2 keyboard or mouse port, the device-driven clock and the data line, and turns each serial frame into a byte on the system-clock side. Both lines rest high when no transfer is running. The device places each bit on the data line while its clock is high. The receiver reads that bit when the device clock falls.

A frame has eleven bits, in this order: a low start bit, eight data bits with the least significant bit first, a parity bit that makes the count of ones across data and parity odd, and a high stop bit. Each raw line passes through a two-flop synchronizer and a glitch filter before any edge detection. A good frame produces the byte together with a one-cycle valid strobe. A bad frame produces a one-cycle error strobe and a two-bit error kind instead. A quiet-time watchdog drops a frame that stalls partway.

The controller has five named states. ST_IDLE waits for a falling clock edge. If the data line is 0 on that edge, the controller goes to ST_DATA. If it is 1, the controller raises a framing error and goes to ST_DISCARD. ST_DATA shifts in eight bits and moves to ST_PARITY on the eighth falling edge. ST_PARITY captures the parity bit and moves to ST_STOP. ST_STOP checks the stop bit and the parity, emits either valid or an error, and returns to ST_IDLE. From ST_DATA, ST_PARITY and ST_STOP, a quiet period with no clock edge leads back to ST_IDLE with a timeout error. From ST_DISCARD, a quiet period leads back to ST_IDLE with no error.

Top module: `ps2_rx_frame`

## Requirements
- R1: While reset is held and right after it, `rx_valid` and `rx_err` are 0 and `rx_byte` is 0x00.
- R2: A good frame drives `rx_byte` with the data bits assembled LSB first (the first data bit lands in bit 0). `rx_valid` is high for exactly one system cycle, SYNC_STAGES+FILT_LEN+1 cycles after the raw clock falls for the stop bit.
- R3: The parity bit must make the number of ones in the eight data bits plus parity odd. If it does not, the block pulses `rx_err` for one cycle with `rx_err_kind` = 2'b10 (parity) and gives no valid strobe.
- R4: A stop bit read as 0 pulses `rx_err` with `rx_err_kind` = 2'b01 (framing) and gives no valid strobe. This check takes priority over the parity check.
- R5: A start bit read as 1 pulses `rx_err` with `rx_err_kind` = 2'b01, SYNC_STAGES+FILT_LEN+1 cycles after that raw falling edge. All further edges are then ignored until both lines have been quiet for TIMEOUT_CYC cycles. No second error and no valid strobe are produced from that frame.
- R6: If the filtered clock shows no edge for TIMEOUT_CYC cycles inside a frame, the partial frame is dropped. `rx_err` pulses with `rx_err_kind` = 2'b11 (timeout), SYNC_STAGES+FILT_LEN+1+TIMEOUT_CYC cycles after the last raw clock edge. The next frame decodes normally.
- R7: A pulse shorter than FILT_LEN system cycles on either raw line has no effect on reception.
- R8: `rx_valid` and `rx_err` are never high in the same cycle. `rx_err` lasts one cycle. `rx_byte` keeps its value except in a cycle where `rx_valid` is high.
- R9: The data line is read only at falling clock edges. Data changes while the device clock is high do not alter the received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_in | input | 1 | Raw device clock line (idle high) |
| ps2_dat_in | input | 1 | Raw device data line (idle high) |
| rx_byte | output | 8 | Last correctly received byte |
| rx_valid | output | 1 | One-cycle strobe for a good frame |
| rx_err | output | 1 | One-cycle strobe for a rejected frame |
| rx_err_kind | output | 2 | Error cause while rx_err is high: 01 framing, 10 parity, 11 timeout |

## Verification
Every result reaches the ports a fixed number of cycles after the raw edge that causes it. The synchronizer and the filter take SYNC_STAGES+FILT_LEN cycles and the controller register takes one more. A timeout adds TIMEOUT_CYC quiet cycles to that count. The bench records the cycle in which it drives each raw clock edge, and a monitor stamps the cycle of every strobe. Each check compares that difference against the latency computed from the parameters. The bench also counts every strobe cycle, so a stretched strobe, a lost strobe or an extra strobe changes the counts it compares.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

    localparam int PS2_DATA_W = 8;
    localparam int PS2_CNT_W  = $clog2(PS2_DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_DISCARD
    } rx_state_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_FRAME   = 2'd1,
        ERR_PARITY  = 2'd2,
        ERR_TIMEOUT = 2'd3
    } err_kind_t;

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic [CW-1:0]          run_q;

    // metastability chain, resets to the idle-high level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
        end
    end

    assign synced = sync_q[SYNC_STAGES-1];

    // accept a new level only after it persists for FILT_LEN cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b1;
            run_q <= '0;
        end else if (synced == clean) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            clean <= synced;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean) |-> clean == $past(synced)); // R7

endmodule

// File: rtl/ps2_bus_front.sv
module ps2_bus_front #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ps2_clk_raw,
    input  logic ps2_dat_raw,
    output logic clk_fall,
    output logic clk_edge,
    output logic data_bit
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_v;
    logic [N_LINES-1:0] clean_v;
    logic               clk_prev_q;

    assign raw_v = {ps2_dat_raw, ps2_clk_raw};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        ps2_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_v[g]),
            .clean(clean_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev_q <= 1'b1;
        end else begin
            clk_prev_q <= clean_v[0];
        end
    end

    assign clk_fall = clk_prev_q & ~clean_v[0];
    assign clk_edge = clk_prev_q ^ clean_v[0];
    assign data_bit = clean_v[1];

endmodule

// File: rtl/ps2_frame_fsm.sv
module ps2_frame_fsm
    import ps2_rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 20000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_fall,
    input  logic                  clk_edge,
    input  logic                  data_bit,
    output logic [PS2_DATA_W-1:0] byte_o,
    output logic                  valid_o,
    output logic                  err_o,
    output err_kind_t             kind_o
);
    localparam int QW = $clog2(TIMEOUT_CYC);
    localparam logic [PS2_CNT_W-1:0] CNT_LAST = PS2_CNT_W'(PS2_DATA_W - 1);

    rx_state_t              state_q, state_d;
    logic [QW-1:0]          quiet_q;
    logic [PS2_CNT_W-1:0]   cnt_q;
    logic [PS2_DATA_W-1:0]  shift_q;
    logic                   par_q;
    logic                   expired;
    logic                   parity_ok;

    assign expired   = (state_q != ST_IDLE) && !clk_edge
                       && (quiet_q == QW'(TIMEOUT_CYC - 1));
    assign parity_ok = ^{shift_q, par_q};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clk_fall) state_d = data_bit ? ST_DISCARD : ST_DATA;
            end
            ST_DATA: begin
                if (expired)                          state_d = ST_IDLE;
                else if (clk_fall && cnt_q == CNT_LAST) state_d = ST_PARITY;
            end
            ST_PARITY: begin
                if (expired)       state_d = ST_IDLE;
                else if (clk_fall) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (expired || clk_fall) state_d = ST_IDLE;
            end
            ST_DISCARD: begin
                if (expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // bit counter, shifter, parity capture and quiet timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= '0;
            cnt_q   <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE || clk_edge) begin
                quiet_q <= '0;
            end else if (!expired) begin
                quiet_q <= quiet_q + 1'b1;
            end

            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == ST_DATA && clk_fall) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (state_q == ST_DATA && clk_fall) begin
                shift_q <= {data_bit, shift_q[PS2_DATA_W-1:1]};
            end

            if (state_q == ST_PARITY && clk_fall) begin
                par_q <= data_bit;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            kind_o  <= ERR_NONE;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            kind_o  <= ERR_NONE;
            unique case (state_q)
                ST_IDLE: begin
                    if (clk_fall && data_bit) begin
                        err_o  <= 1'b1;
                        kind_o <= ERR_FRAME;
                    end
                end
                ST_DATA, ST_PARITY: begin
                    if (expired) begin
                        err_o  <= 1'b1;
                        kind_o <= ERR_TIMEOUT;
                    end
                end
                ST_STOP: begin
                    if (expired) begin
                        err_o  <= 1'b1;
                        kind_o <= ERR_TIMEOUT;
                    end else if (clk_fall) begin
                        if (!data_bit) begin
                            err_o  <= 1'b1;
                            kind_o <= ERR_FRAME;
                        end else if (!parity_ok) begin
                            err_o  <= 1'b1;
                            kind_o <= ERR_PARITY;
                        end else begin
                            valid_o <= 1'b1;
                            byte_o  <= shift_q;
                        end
                    end
                end
                ST_DISCARD: begin
                end
                default: begin
                end
            endcase
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R2

    AST_VALID_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(state_q) == ST_STOP); // R2

    AST_NO_VALID_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o)); // R8

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R8

    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(byte_o)); // R8

    AST_TIMEOUT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && kind_o == ERR_TIMEOUT) |->
            ($past(state_q) != ST_IDLE && $past(state_q) != ST_DISCARD)); // R6

    AST_DISCARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_DISCARD) |-> !(valid_o || err_o)); // R5

endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int TIMEOUT_CYC = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       rx_err,
    output logic [1:0] rx_err_kind
);
    import ps2_rx_pkg::*;

    logic      clk_fall;
    logic      clk_edge;
    logic      data_bit;
    err_kind_t kind;

    ps2_bus_front #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .ps2_clk_raw(ps2_clk_in),
        .ps2_dat_raw(ps2_dat_in),
        .clk_fall   (clk_fall),
        .clk_edge   (clk_edge),
        .data_bit   (data_bit)
    );

    ps2_frame_fsm #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_fall(clk_fall),
        .clk_edge(clk_edge),
        .data_bit(data_bit),
        .byte_o  (rx_byte),
        .valid_o (rx_valid),
        .err_o   (rx_err),
        .kind_o  (kind)
    );

    assign rx_err_kind = kind;

    AST_KIND_ONLY_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_err |-> rx_err_kind == 2'b00); // R8

endmodule

// File: tb/ps2_rx_frame_bench.sv
`timescale 1ns/1ps
module ps2_rx_frame_bench;

    localparam int SYNC = 2;
    localparam int FILT = 4;
    localparam int TO   = 300;
    localparam int HP   = 40;
    localparam int LAT  = SYNC + FILT + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_clk_in = 1'b1;
    logic       ps2_dat_in = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_err;
    logic [1:0] rx_err_kind;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    int n_valid = 0;
    int n_err = 0;
    int valid_cyc = 0;
    int err_cyc = 0;
    logic [7:0] last_byte = 8'h00;
    logic [1:0] last_kind = 2'b00;
    bit done = 0;

    always #2.5 clk = ~clk;

    ps2_rx_frame #(
        .SYNC_STAGES(SYNC),
        .FILT_LEN   (FILT),
        .TIMEOUT_CYC(TO)
    ) u_ps2_rx_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .ps2_clk_in (ps2_clk_in),
        .ps2_dat_in (ps2_dat_in),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_err     (rx_err),
        .rx_err_kind(rx_err_kind)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            n_valid++;
            last_byte = rx_byte;
            valid_cyc = cyc;
        end
        if (rst_n && rx_err) begin
            n_err++;
            last_kind = rx_err_kind;
            err_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bit 0 of bits goes first; records first falling and last raw edge cycles
    task automatic drive_bits(input logic [10:0] bits, input int nbits, input bit noisy,
                              output int first_fall, output int last_fall, output int last_edge);
        first_fall = -1;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            ps2_dat_in = bits[i];
            if (noisy) begin
                idle(4);
                ps2_dat_in = ~bits[i];
                idle(8);
                ps2_dat_in = bits[i];
            end
            idle(HP / 2);
            ps2_clk_in = 1'b0;
            if (first_fall < 0) first_fall = cyc;
            last_fall = cyc;
            last_edge = cyc;
            idle(HP);
            ps2_clk_in = 1'b1;
            last_edge = cyc;
            idle(HP / 2);
        end
        ps2_dat_in = 1'b1;
    endtask

    function automatic logic [10:0] make_frame(input logic [7:0] b, input bit start_v,
                                               input bit par_flip, input bit stop_v);
        return {stop_v, (~^b) ^ par_flip, b, start_v};
    endfunction

    task automatic t_reset();
        idle(3);
        check(rx_valid == 1'b0, "R1 valid in reset", rx_valid, 0);
        check(rx_err == 1'b0, "R1 err in reset", rx_err, 0);
        check(rx_byte == 8'h00, "R1 byte in reset", rx_byte, 0);
        rst_n = 1'b1;
        idle(5);
        check(rx_valid == 1'b0 && rx_err == 1'b0, "R1 outputs after reset",
              {rx_valid, rx_err}, 0);
        check(rx_byte == 8'h00, "R1 byte after reset", rx_byte, 0);
    endtask

    task automatic t_good(input logic [7:0] b, input bit noisy, input string req);
        int v0, e0, ff, lf, le;
        v0 = n_valid;
        e0 = n_err;
        drive_bits(make_frame(b, 1'b0, 1'b0, 1'b1), 11, noisy, ff, lf, le);
        idle(LAT + 10);
        check(n_valid == v0 + 1, {req, " one valid cycle"}, n_valid - v0, 1);
        check(n_err == e0, {req, " no error"}, n_err - e0, 0);
        check(last_byte == b, {req, " byte LSB first"}, last_byte, b);
        check(valid_cyc - lf == LAT, {req, " valid latency"}, valid_cyc - lf, LAT);
        check(rx_byte == b, {req, " byte held"}, rx_byte, b);
        idle(HP);
    endtask

    task automatic t_parity_err();
        int v0, e0, ff, lf, le;
        v0 = n_valid;
        e0 = n_err;
        drive_bits(make_frame(8'h3C, 1'b0, 1'b1, 1'b1), 11, 1'b0, ff, lf, le);
        idle(LAT + 10);
        check(n_err == e0 + 1, "R3 parity error pulse", n_err - e0, 1);
        check(last_kind == 2'b10, "R3 parity kind", last_kind, 2);
        check(err_cyc - lf == LAT, "R3 parity latency", err_cyc - lf, LAT);
        check(n_valid == v0, "R3 no valid on bad parity", n_valid - v0, 0);
        check(rx_byte == 8'hA5, "R8 byte kept after parity error", rx_byte, 8'hA5);
        idle(HP);
    endtask

    task automatic t_stop_err();
        int v0, e0, ff, lf, le;
        v0 = n_valid;
        e0 = n_err;
        // stop bit low and parity also wrong: framing must win
        drive_bits(make_frame(8'h5A, 1'b0, 1'b1, 1'b0), 11, 1'b0, ff, lf, le);
        idle(LAT + 10);
        check(n_err == e0 + 1, "R4 stop error pulse", n_err - e0, 1);
        check(last_kind == 2'b01, "R4 framing kind", last_kind, 1);
        check(n_valid == v0, "R4 no valid on bad stop", n_valid - v0, 0);
        check(rx_byte == 8'hA5, "R8 byte kept after stop error", rx_byte, 8'hA5);
        idle(TO + HP);
    endtask

    task automatic t_start_err();
        int v0, e0, ff, lf, le;
        v0 = n_valid;
        e0 = n_err;
        drive_bits(make_frame(8'h00, 1'b1, 1'b0, 1'b1), 11, 1'b0, ff, lf, le);
        idle(LAT + TO + 30);
        check(n_err == e0 + 1, "R5 single start error", n_err - e0, 1);
        check(last_kind == 2'b01, "R5 framing kind", last_kind, 1);
        check(err_cyc - ff == LAT, "R5 start error latency", err_cyc - ff, LAT);
        check(n_valid == v0, "R5 rest of frame ignored", n_valid - v0, 0);
        t_good(8'h81, 1'b0, "R5 recovery");
    endtask

    task automatic t_timeout();
        int v0, e0, ff, lf, le;
        v0 = n_valid;
        e0 = n_err;
        drive_bits(make_frame(8'hFF, 1'b0, 1'b0, 1'b1), 4, 1'b0, ff, lf, le);
        idle(LAT + TO + 30);
        check(n_err == e0 + 1, "R6 timeout pulse", n_err - e0, 1);
        check(last_kind == 2'b11, "R6 timeout kind", last_kind, 3);
        check(err_cyc - le == LAT + TO, "R6 timeout latency", err_cyc - le, LAT + TO);
        check(n_valid == v0, "R6 partial frame dropped", n_valid - v0, 0);
        t_good(8'h6E, 1'b0, "R6 recovery");
    endtask

    task automatic t_glitch();
        int v0, e0;
        v0 = n_valid;
        e0 = n_err;
        @(negedge clk);
        ps2_dat_in = 1'b0;
        idle(20);
        ps2_clk_in = 1'b0;
        idle(FILT - 2);
        ps2_clk_in = 1'b1;
        idle(20);
        ps2_dat_in = 1'b1;
        idle(20);
        ps2_dat_in = 1'b0;
        idle(FILT - 1);
        ps2_dat_in = 1'b1;
        idle(LAT + TO + 30);
        check(n_err == e0, "R7 glitch raises no error", n_err - e0, 0);
        check(n_valid == v0, "R7 glitch raises no valid", n_valid - v0, 0);
        t_good(8'hC3, 1'b0, "R7 after glitch");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_good(8'hA5, 1'b0, "R2 A5");
        t_good(8'h00, 1'b0, "R2 00");
        t_good(8'hFF, 1'b0, "R2 FF");
        t_good(8'h1C, 1'b0, "R2 1C");
        t_good(8'h96, 1'b1, "R9 noisy data");
        t_good(8'hA5, 1'b0, "R2 A5 again");
        t_parity_err();
        t_stop_err();
        t_start_err();
        t_timeout();
        t_glitch();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

endmodule